// File: doc/BRIEF.md
# RX Interrupt Coalescing Timer

This block decides when a receive path should tell software that frames are waiting. It counts frames as the receive DMA reports them finished. It also keeps a coarse timer that runs only while at least one finished frame has not yet been reported. It raises a one-cycle done event as soon as either the frame count or the elapsed time reaches its programmed limit. After each event, both counters start again from zero.

Before each done event, the block emits a one-cycle strobe that tells the completion-index register to take its new value. The strobe comes exactly one cycle before the event, so any handler woken by the event already sees an up-to-date index.

The timer counts in blocks of 2048 enabled clocks, so a long time limit needs only a small counter. Both inputs and both outputs are plain control pulses with no back-pressure. The DMA can never be stalled by this block, and every completion pulse is counted in the cycle it arrives.

Top module: `rx_coalesce_timer`

## Requirements
- R1: After reset is released, `idx_update` and `rx_done` are low, and both counters and the prescaler start from zero.
- R2: The frame limit is read from `cfg_word[8:0]`. When it is N > 0, the N-th `frame_done` pulse since the previous event is the firing cycle. `idx_update` is high in the cycle after the firing cycle, and `rx_done` is high in the cycle after that. This also holds for N = 511.
- R3: The time limit is read from `cfg_word[19:12]`. When it is T > 0, the event fires on the T-th block boundary counted while a finished frame is pending.
- R4: A block boundary is every 2048th cycle in which `tick_en` is high. Cycles with `tick_en` low neither advance the prescaler nor form a boundary.
- R5: The time counter advances only while the frame counter is non-zero. No event ever fires with zero frames pending, even when `tick_en` stays high indefinitely.
- R6: The firing cycle clears both the frame counter and the time counter. A `frame_done` that arrives in the firing cycle is counted in the batch being closed.
- R7: A frame limit of 0 turns the count trigger off. Frames then only accumulate, up to a saturation point of 511.
- R8: A time limit of 0 turns the time trigger off.
- R9: When both limits are 0, every `frame_done` pulse produces its own `idx_update` and `rx_done` pair.
- R10: Every `rx_done` pulse is preceded, in the cycle directly before it, by an `idx_update` pulse. Back-to-back firings give back-to-back pairs.
- R11: Bits of `cfg_word` outside [8:0] and [19:12] have no effect on when events fire.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done | input | 1 | One-cycle pulse: a frame has fully drained into its buffer |
| tick_en | input | 1 | Clock enable for the block prescaler |
| cfg_word | input | 32 | Frame limit in [8:0], time limit in [19:12], other bits ignored |
| idx_update | output | 1 | Strobe that loads the completion index |
| rx_done | output | 1 | RX-done event pulse |

## Verification
Errors in this block show up at the ports as changes in event timing or event count.

If the frame counter is not cleared, or is cleared at the wrong time, the next batch fires early or late. This is visible on `rx_done` within one batch of frames. If the prescaler is wrong, or the time counter is not cleared, the time-triggered event moves by whole multiples of 2048 enabled cycles. The bench predicts the firing cycle from its own count of enabled cycles, so a shift of even one cycle is caught.

If the strobe-to-event pipeline is broken, an `rx_done` appears without an `idx_update` in the cycle before it. This is seen at the very first event.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  // Source of a firing decision, used for readability of the trigger logic.
  typedef enum logic [1:0] {
    FIRE_NONE = 2'd0,
    FIRE_COUNT = 2'd1,
    FIRE_TIME = 2'd2,
    FIRE_EACH = 2'd3
  } fire_src_e;
endpackage

// File: rtl/rxc_prescaler.sv
module rxc_prescaler #(
  parameter int unsigned W = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;
  end

  assign tick_o = en && (&cnt);

  // R4: a boundary wraps the prescaler back to zero
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt == '0));
  // R4: disabled cycles leave the prescaler untouched
  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));
endmodule

// File: rtl/rxc_sat_counter.sv
module rxc_sat_counter #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (clr) q <= '0;
    else if (inc && !(&q)) q <= q + 1'b1;
  end

  // R6: a clear request empties the counter on the next cycle
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
  // R7: saturation, the counter never wraps from all-ones to zero unless cleared
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ((&q) && !clr) |=> (&q));
endmodule

// File: rtl/rxc_fire_seq.sv
module rxc_fire_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic idx_update,
  output logic rx_done
);
  logic idx_q;
  logic done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      idx_q  <= fire;
      done_q <= idx_q;
    end
  end

  assign idx_update = idx_q;
  assign rx_done    = done_q;

  // R10: the index strobe is always followed by the event
  a_r10_strobe_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    idx_update |=> rx_done);
  // R10: no event without the strobe one cycle earlier
  a_r10_done_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(idx_update));
endmodule

// File: rtl/rx_coalesce_timer.sv
module rx_coalesce_timer #(
  parameter int unsigned CFG_W    = 32,
  parameter int unsigned PKT_LSB  = 0,
  parameter int unsigned PKT_W    = 9,
  parameter int unsigned TIME_LSB = 12,
  parameter int unsigned TIME_W   = 8,
  parameter int unsigned PRESC_W  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done,
  input  logic             tick_en,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             idx_update,
  output logic             rx_done
);
  import rxc_pkg::*;

  localparam int unsigned PKT_SUM_W  = PKT_W + 1;
  localparam int unsigned TIME_SUM_W = TIME_W + 1;

  logic [PKT_W-1:0]  pkt_lim;
  logic [TIME_W-1:0] time_lim;
  logic [PKT_W-1:0]  pkt_cnt;
  logic [TIME_W-1:0] time_cnt;
  logic              blk_tick;
  logic              pending;
  logic              time_adv;
  logic              fire;
  fire_src_e         src;

  logic [PKT_SUM_W-1:0]  pkt_next;
  logic [TIME_SUM_W-1:0] time_next;

  // R11: only the two limit fields are decoded
  assign pkt_lim  = cfg_word[PKT_LSB +: PKT_W];
  assign time_lim = cfg_word[TIME_LSB +: TIME_W];

  rxc_prescaler #(.W(PRESC_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (tick_en),
    .tick_o(blk_tick)
  );

  assign pending  = (pkt_cnt != '0);
  assign time_adv = blk_tick && pending;

  assign pkt_next  = {1'b0, pkt_cnt} + PKT_SUM_W'(1);
  assign time_next = {1'b0, time_cnt} + TIME_SUM_W'(1);

  always_comb begin
    src = FIRE_NONE;
    if (pkt_lim == '0 && time_lim == '0) begin
      if (frame_done) src = FIRE_EACH;
    end else begin
      if (pkt_lim != '0 && frame_done && pkt_next >= {1'b0, pkt_lim})
        src = FIRE_COUNT;
      else if (time_lim != '0 && time_adv && time_next >= {1'b0, time_lim})
        src = FIRE_TIME;
    end
  end

  assign fire = (src != FIRE_NONE);

  rxc_sat_counter #(.W(PKT_W)) u_pkt_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (frame_done),
    .clr  (fire),
    .q    (pkt_cnt)
  );

  rxc_sat_counter #(.W(TIME_W)) u_time_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (time_adv),
    .clr  (fire),
    .q    (time_cnt)
  );

  rxc_fire_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .idx_update(idx_update),
    .rx_done   (rx_done)
  );

  // R5: never fire with nothing pending
  a_r5_no_empty_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (pending || frame_done));
  // R5: the time counter stays at zero while nothing is pending
  a_r5_idle_time_still: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !frame_done) |=> (time_cnt == '0));
  // R6: both counters restart after a firing
  a_r6_both_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (pkt_cnt == '0 && time_cnt == '0));
  // R7: a zero frame limit only fires on a block boundary
  a_r7_count_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_lim == '0 && time_lim != '0 && !blk_tick) |-> !fire);
  // R8: a zero time limit only fires on a frame
  a_r8_time_off: assert property (@(posedge clk) disable iff (!rst_n)
    (time_lim == '0 && !frame_done) |-> !fire);
  // R9: both limits zero, every frame is reported as a strobe next cycle
  a_r9_each_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_lim == '0 && time_lim == '0 && frame_done) |=> idx_update);
endmodule

// File: tb/tb_rx_coalesce_timer.sv
`timescale 1ns/1ps
module tb_rx_coalesce_timer;
  localparam int BLK = 2048;

  typedef struct packed {
    logic [31:0] cfg;
    logic [15:0] nfr;
    logic [7:0]  gap;
    logic [15:0] exp;
  } vec_t;

  // limit fields: frames in [8:0], time in [19:12]
  localparam vec_t VECS [8] = '{
    '{32'h0000_0001, 16'd5,   8'd1, 16'd5},  // R2 limit 1
    '{32'h0000_0003, 16'd7,   8'd1, 16'd2},  // R6 counter cleared per batch
    '{32'h0000_0004, 16'd4,   8'd0, 16'd1},  // R2 back-to-back frames
    '{32'h0000_0000, 16'd3,   8'd1, 16'd3},  // R9 both zero
    '{32'h0000_5000, 16'd6,   8'd1, 16'd0},  // R7 count trigger off, no ticks
    '{32'hFFF0_0E02, 16'd4,   8'd1, 16'd2},  // R11 junk bits ignored
    '{32'h0000_0001, 16'd3,   8'd0, 16'd3},  // R10 back-to-back pairs
    '{32'h0000_01FF, 16'd511, 8'd0, 16'd1}   // R2 largest frame limit
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_done = 1'b0;
  logic        tick_en = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        idx_update;
  logic        rx_done;

  int total = 0;
  int bad = 0;
  int en_total = 0;
  int done_cnt = 0;
  int idx_cnt = 0;
  int order_bad = 0;
  logic prev_idx = 1'b0;
  logic cur_idx = 1'b0;
  logic cur_done = 1'b0;

  always #2 clk = ~clk;

  rx_coalesce_timer dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_done(frame_done),
    .tick_en   (tick_en),
    .cfg_word  (cfg_word),
    .idx_update(idx_update),
    .rx_done   (rx_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    done_cnt = 0; idx_cnt = 0; order_bad = 0;
  endtask

  task automatic cyc(input logic fd, input logic en);
    frame_done = fd;
    tick_en = en;
    @(negedge clk);
    if (en) en_total++;
    cur_idx = idx_update;
    cur_done = rx_done;
    if (cur_done) begin
      done_cnt++;
      if (!prev_idx) order_bad++;
    end
    if (cur_idx) idx_cnt++;
    prev_idx = cur_idx;
    frame_done = 1'b0;
    tick_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    frame_done = 1'b0;
    tick_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    en_total = 0;
    prev_idx = 1'b0;
    clear_mon();
  endtask

  task automatic run_en(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b1);
  endtask

  // Time trigger: T boundaries after one pending frame, exact firing cycle.
  task automatic time_case(input int t, input string tag);
    int need;
    cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b0);
    clear_mon();
    need = (BLK - (en_total % BLK)) + (t - 1) * BLK;
    run_en(need - 1);
    chk(done_cnt == 0 && idx_cnt == 0, {tag, " early event"}, done_cnt + idx_cnt, 0);
    cyc(1'b0, 1'b1);
    chk(cur_idx == 1'b1 && cur_done == 1'b0, {tag, " strobe on boundary"}, int'(cur_idx), 1);
    cyc(1'b0, 1'b0);
    chk(cur_done == 1'b1 && cur_idx == 1'b0, {tag, " event after strobe"}, int'(cur_done), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    cyc(1'b0, 1'b0);
    chk(idx_update == 1'b0, "R1 idx_update after reset", int'(idx_update), 0);
    chk(rx_done == 1'b0, "R1 rx_done after reset", int'(rx_done), 0);

    // Table walk
    for (int v = 0; v < 8; v++) begin
      do_reset();
      cfg_word = VECS[v].cfg;
      for (int f = 0; f < int'(VECS[v].nfr); f++) begin
        cyc(1'b1, 1'b0);
        for (int g = 0; g < int'(VECS[v].gap); g++) cyc(1'b0, 1'b0);
      end
      repeat (4) cyc(1'b0, 1'b0);
      chk(done_cnt == int'(VECS[v].exp), $sformatf("R2/R6/R7/R9/R11 vector %0d event count", v),
          done_cnt, int'(VECS[v].exp));
      chk(idx_cnt == done_cnt, $sformatf("R10 vector %0d strobe count", v), idx_cnt, done_cnt);
      chk(order_bad == 0, $sformatf("R10 vector %0d order", v), order_bad, 0);
    end

    // R2: exact cycle of strobe and event for a frame limit of 2
    do_reset();
    cfg_word = 32'h0000_0002;
    cyc(1'b1, 1'b0);
    chk(cur_idx == 1'b0, "R2 no strobe after first frame", int'(cur_idx), 0);
    cyc(1'b1, 1'b0);
    chk(cur_idx == 1'b1 && cur_done == 1'b0, "R2 strobe after second frame", int'(cur_idx), 1);
    cyc(1'b0, 1'b0);
    chk(cur_done == 1'b1 && cur_idx == 1'b0, "R2 event one cycle later", int'(cur_done), 1);

    // R5: long enabled run with nothing pending, then R3/R4 time trigger
    do_reset();
    cfg_word = 32'h0000_2000;  // time limit 2, frame limit 0
    run_en(5000);
    chk(done_cnt == 0 && idx_cnt == 0, "R5 no event while empty", done_cnt, 0);
    time_case(2, "R3 R4 first batch");
    // R6: time counter restarted, second batch needs the full span again
    time_case(2, "R6 second batch");

    // R8: time limit off, frames below limit never fire however long
    do_reset();
    cfg_word = 32'h0000_0005;
    repeat (3) cyc(1'b1, 1'b0);
    run_en(3 * BLK);
    chk(done_cnt == 0, "R8 no timed event", done_cnt, 0);
    cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b0);
    chk(done_cnt == 1 && idx_cnt == 1, "R8 count still fires", done_cnt, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule